// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a very small data cache. It sits between a byte-wide load/store port and a 16-byte backing memory. It holds 8 bytes in two sets of two ways, with 2-byte lines.

Each line has the following state:
- a valid flag
- a dirty flag
- a tag

Each set also has one bit that names its most recently used way. Writes are write-back and write-allocate. A store that hits only changes the cached line. A store that misses first brings the line in and then merges the byte.

On a miss the controller works in this order:
1. It picks a way. An empty way is used first. If neither way is empty, the way that was not used last is taken.
2. If the chosen line is dirty, it writes the line back to memory.
3. It reads the new line from memory.
4. It finishes the access.

The memory side uses a request/acknowledge handshake that carries a whole 2-byte line. Two counters report how many accesses hit and how many missed.

A requester drives `req_i` together with the access fields and holds them until `ready_o` pulses for one cycle. It then drops or changes the request.

Top module: `wb2way_cache`

## Requirements
- R1: The 4-bit byte address is split as follows. Bit 0 selects the byte inside a line: 0 is line bits 7:0 and 1 is line bits 15:8. Bit 1 selects the set. Bits 3:2 are the tag. The memory line address is address bits 3:1.
- R2: A load that hits returns its byte with `ready_o` high in the cycle after the request is accepted. It causes no memory transaction.
- R3: A load that misses a clean or empty way performs exactly one memory read of line address bits 3:1. It then returns the byte chosen by the offset.
- R4: A miss fills an empty way before it evicts a valid one. Two different lines of the same set can therefore be resident together. When both ways are empty, way 0 is filled.
- R5: When both ways of the set are valid, a miss evicts the way that is not most recently used. Every hit and every fill makes the way it touched the most recently used way.
- R6: A store that hits updates only the cached byte and marks the line dirty. It issues no memory write, and later loads return the stored byte.
- R7: A store that misses reads the line from memory and merges the store byte. The line is left dirty, and no memory write is issued for the store.
- R8: A dirty victim is written to memory as a full line at line address {victim tag, set}, and this write comes before the fill read. A clean victim is dropped without a write.
- R9: Each completed access adds exactly one to either the hit counter or the miss counter, according to its outcome.
- R10: `mem_req_o` stays high, with address, direction and write data unchanged, until the cycle in which `mem_ack_i` is sampled high.
- R11: Reset clears all valid, dirty and most-recently-used state and both counters. Because of this, the first access after reset misses.
- R12: `ready_o` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W (4) | Byte address |
| wdata_i | input | DATA_W (8) | Store byte |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W (8) | Load byte; for a store, the stored byte |
| hit_cnt_o | output | CNT_W (16) | Hit counter |
| miss_cnt_o | output | CNT_W (16) | Miss counter |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr_o | output | ADDR_W-OFF_W (3) | Memory line address |
| mem_wdata_o | output | 16 | Line data for a write-back |
| mem_ack_i | input | 1 | One-cycle acknowledge; read data is valid with it |
| mem_rdata_i | input | 16 | Line data returned by a read |

## Verification
The bench builds the cache with its default geometry: a 4-bit address, a 1-bit offset, a 1-bit index and 8-bit data. With only two ways per set, a handful of accesses to set 0 is enough to saturate it. Those accesses exercise non-MRU eviction, clean drops, and a dirty write-back followed by a fill, in a fixed and predictable order. Reloading the written-back line shows that the merged store byte reached memory. Accesses to set 1 show that the index bit keeps the two sets apart.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2,
    ST_DONE = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_store.sv
module cache_store #(
  parameter int IDX_W = 1,
  parameter int TAG_W = 2,
  parameter int BLK_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  wr_en_i,
  input  logic                  wr_way_i,
  input  logic                  wr_dirty_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  logic [BLK_W-1:0]      wr_data_i,
  input  logic                  mru_en_i,
  input  logic                  mru_way_i,
  output logic [1:0]            valid_o,
  output logic [1:0]            dirty_o,
  output logic [1:0][TAG_W-1:0] tag_o,
  output logic [1:0][BLK_W-1:0] data_o,
  output logic                  mru_o
);
  localparam int SETS = 1 << IDX_W;

  logic [1:0]            v_all [SETS];
  logic [1:0]            d_all [SETS];
  logic                  m_all [SETS];
  logic [1:0][TAG_W-1:0] t_all [SETS];
  logic [1:0][BLK_W-1:0] b_all [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic                  v_q, v1_q, d_q, d1_q, m_q;
    logic [1:0][TAG_W-1:0] t_q;
    logic [1:0][BLK_W-1:0] b_q;
    logic                  sel;

    assign sel = (idx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q  <= 1'b0;
        v1_q <= 1'b0;
        d_q  <= 1'b0;
        d1_q <= 1'b0;
        m_q  <= 1'b0;
      end else begin
        if (wr_en_i && sel && !wr_way_i) begin
          v_q <= 1'b1;
          d_q <= wr_dirty_i;
        end
        if (wr_en_i && sel && wr_way_i) begin
          v1_q <= 1'b1;
          d1_q <= wr_dirty_i;
        end
        if (mru_en_i && sel) m_q <= mru_way_i;
      end
    end

    // tag and data need no reset: valid gates them
    always_ff @(posedge clk_i) begin
      if (wr_en_i && sel) begin
        t_q[wr_way_i] <= wr_tag_i;
        b_q[wr_way_i] <= wr_data_i;
      end
    end

    assign v_all[s] = {v1_q, v_q};
    assign d_all[s] = {d1_q, d_q};
    assign m_all[s] = m_q;
    assign t_all[s] = t_q;
    assign b_all[s] = b_q;
  end

  assign valid_o = v_all[idx_i];
  assign dirty_o = d_all[idx_i];
  assign mru_o   = m_all[idx_i];
  assign tag_o   = t_all[idx_i];
  assign data_o  = b_all[idx_i];
endmodule

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int TAG_W = 2
) (
  input  logic [1:0]            valid_i,
  input  logic [1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic                  mru_i,
  output logic                  hit_o,
  output logic                  hit_way_o,
  output logic                  victim_way_o
);
  logic [1:0] match;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tag_i[w] == req_tag_i);
  end

  assign hit_o     = |match;
  assign hit_way_o = match[1];

  // empty way first (way 0 before way 1), else the non-MRU way
  always_comb begin
    if (!valid_i[0])      victim_way_o = 1'b0;
    else if (!valid_i[1]) victim_way_o = 1'b1;
    else                  victim_way_o = ~mru_i;
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int BLK_B   = 1 << OFF_W,
  localparam int BLK_W   = DATA_W * BLK_B,
  localparam int BADDR_W = ADDR_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  ready_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [CNT_W-1:0]      hit_cnt_o,
  output logic [CNT_W-1:0]      miss_cnt_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [BADDR_W-1:0]    mem_addr_o,
  output logic [BLK_W-1:0]      mem_wdata_o,
  input  logic                  mem_ack_i,
  input  logic [BLK_W-1:0]      mem_rdata_i,
  output logic [IDX_W-1:0]      idx_o,
  output logic [TAG_W-1:0]      req_tag_o,
  input  logic                  hit_i,
  input  logic                  hit_way_i,
  input  logic                  victim_way_i,
  input  logic [1:0]            line_valid_i,
  input  logic [1:0]            line_dirty_i,
  input  logic [1:0][TAG_W-1:0] line_tag_i,
  input  logic [1:0][BLK_W-1:0] line_data_i,
  output logic                  wr_en_o,
  output logic                  wr_way_o,
  output logic                  wr_dirty_o,
  output logic [TAG_W-1:0]      wr_tag_o,
  output logic [BLK_W-1:0]      wr_data_o,
  output logic                  mru_en_o,
  output logic                  mru_way_o
);
  cache_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic              we_q, way_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CNT_W-1:0]  hit_cnt_q, miss_cnt_q;
  logic [OFF_W-1:0]  off;
  logic              accept;

  function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                input logic [OFF_W-1:0] o,
                                                input logic [DATA_W-1:0] b);
    logic [BLK_W-1:0] r;
    r = blk;
    for (int i = 0; i < BLK_B; i++) begin
      if (o == OFF_W'(i)) r[i*DATA_W +: DATA_W] = b;
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] get_byte(input logic [BLK_W-1:0] blk,
                                                 input logic [OFF_W-1:0] o);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < BLK_B; i++) begin
      if (o == OFF_W'(i)) r = blk[i*DATA_W +: DATA_W];
    end
    return r;
  endfunction

  // index/tag come from the port while idle, from the latch during a miss
  assign cur_addr  = (state_q == ST_IDLE) ? addr_i : addr_q;
  assign off       = cur_addr[OFF_W-1:0];
  assign idx_o     = cur_addr[OFF_W +: IDX_W];
  assign req_tag_o = cur_addr[ADDR_W-1 -: TAG_W];
  assign accept    = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d     = state_q;
    wr_en_o     = 1'b0;
    wr_way_o    = way_q;
    wr_dirty_o  = 1'b0;
    wr_tag_o    = req_tag_o;
    wr_data_o   = mem_rdata_i;
    mru_en_o    = 1'b0;
    mru_way_o   = way_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q[ADDR_W-1:OFF_W];
    mem_wdata_o = line_data_i[way_q];
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (hit_i) begin
            mru_en_o  = 1'b1;
            mru_way_o = hit_way_i;
            if (we_i) begin
              wr_en_o    = 1'b1;
              wr_way_o   = hit_way_i;
              wr_dirty_o = 1'b1;
              wr_data_o  = put_byte(line_data_i[hit_way_i], off, wdata_i);
            end
            state_d = ST_DONE;
          end else if (line_valid_i[victim_way_i] && line_dirty_i[victim_way_i]) begin
            state_d = ST_WB;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_WB: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = {line_tag_i[way_q], idx_o};
        if (mem_ack_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          wr_en_o    = 1'b1;
          wr_dirty_o = we_q;
          wr_data_o  = we_q ? put_byte(mem_rdata_i, off, wdata_q) : mem_rdata_i;
          mru_en_o   = 1'b1;
          state_d    = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      way_q      <= 1'b0;
      rdata_q    <= '0;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= addr_i;
        we_q    <= we_i;
        wdata_q <= wdata_i;
        way_q   <= hit_i ? hit_way_i : victim_way_i;
        if (hit_i) begin
          hit_cnt_q <= hit_cnt_q + 1'b1;
          rdata_q   <= we_i ? wdata_i : get_byte(line_data_i[hit_way_i], off);
        end else begin
          miss_cnt_q <= miss_cnt_q + 1'b1;
        end
      end
      if (state_q == ST_FILL && mem_ack_i) begin
        rdata_q <= we_q ? wdata_q : get_byte(mem_rdata_i, off);
      end
    end
  end

  assign ready_o    = (state_q == ST_DONE);
  assign rdata_o    = rdata_q;
  assign hit_cnt_o  = hit_cnt_q;
  assign miss_cnt_o = miss_cnt_q;
endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache #(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int BLK_W   = DATA_W * (1 << OFF_W),
  localparam int BADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ready_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]   hit_cnt_o,
  output logic [CNT_W-1:0]   miss_cnt_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [BADDR_W-1:0] mem_addr_o,
  output logic [BLK_W-1:0]   mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [BLK_W-1:0]   mem_rdata_i
);
  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      req_tag;
  logic                  hit, hit_way, victim_way, mru;
  logic [1:0]            line_valid, line_dirty;
  logic [1:0][TAG_W-1:0] line_tag;
  logic [1:0][BLK_W-1:0] line_data;
  logic                  wr_en, wr_way, wr_dirty, mru_en, mru_way;
  logic [TAG_W-1:0]      wr_tag;
  logic [BLK_W-1:0]      wr_data;

  cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (idx),
    .wr_en_i    (wr_en),
    .wr_way_i   (wr_way),
    .wr_dirty_i (wr_dirty),
    .wr_tag_i   (wr_tag),
    .wr_data_i  (wr_data),
    .mru_en_i   (mru_en),
    .mru_way_i  (mru_way),
    .valid_o    (line_valid),
    .dirty_o    (line_dirty),
    .tag_o      (line_tag),
    .data_o     (line_data),
    .mru_o      (mru)
  );

  cache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .valid_i      (line_valid),
    .tag_i        (line_tag),
    .req_tag_i    (req_tag),
    .mru_i        (mru),
    .hit_o        (hit),
    .hit_way_o    (hit_way),
    .victim_way_o (victim_way)
  );

  cache_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .ready_o      (ready_o),
    .rdata_o      (rdata_o),
    .hit_cnt_o    (hit_cnt_o),
    .miss_cnt_o   (miss_cnt_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .idx_o        (idx),
    .req_tag_o    (req_tag),
    .hit_i        (hit),
    .hit_way_i    (hit_way),
    .victim_way_i (victim_way),
    .line_valid_i (line_valid),
    .line_dirty_i (line_dirty),
    .line_tag_i   (line_tag),
    .line_data_i  (line_data),
    .wr_en_o      (wr_en),
    .wr_way_o     (wr_way),
    .wr_dirty_o   (wr_dirty),
    .wr_tag_o     (wr_tag),
    .wr_data_o    (wr_data),
    .mru_en_o     (mru_en),
    .mru_way_o    (mru_way)
  );
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int CNT_W   = 16,
  parameter int BADDR_W = 3,
  parameter int BLK_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ready_o,
  input logic [CNT_W-1:0]   hit_cnt_o,
  input logic [CNT_W-1:0]   miss_cnt_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [BADDR_W-1:0] mem_addr_o,
  input logic [BLK_W-1:0]   mem_wdata_o,
  input logic               mem_ack_i
);
  p_ready_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_hit_fast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> (ready_o && !mem_req_o));

  p_hit_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> (hit_cnt_o == CNT_W'($past(hit_cnt_o) + 1'b1)));

  p_miss_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != $past(miss_cnt_o)) |-> (miss_cnt_o == CNT_W'($past(miss_cnt_o) + 1'b1)));

  p_one_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((hit_cnt_o != $past(hit_cnt_o)) && (miss_cnt_o != $past(miss_cnt_o))));

  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_wb_then_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));

  p_fill_then_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> ready_o);
endmodule

bind wb2way_cache cache_chk #(.CNT_W(CNT_W), .BADDR_W(BADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .hit_cnt_o   (hit_cnt_o),
  .miss_cnt_o  (miss_cnt_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/wb2way_cache_tb_top.sv
`timescale 1ns/1ps
module wb2way_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready_o;
  logic [7:0]  rdata_o;
  logic [15:0] hit_cnt_o, miss_cnt_o;
  logic        mem_req_o, mem_we_o;
  logic [2:0]  mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0, fails = 0;
  int exp_hits = 0, exp_misses = 0;
  int rd_n = 0, wr_n = 0, txn_n = 0;
  logic        txn_we   [64];
  logic [2:0]  txn_addr [64];
  logic [15:0] txn_data [64];
  logic [15:0] mem_q    [8];
  logic        lat;
  int          hs_err = 0, rdy_err = 0;
  logic        prev_pend = 1'b0, prev_we = 1'b0, prev_rdy = 1'b0;
  logic [2:0]  prev_addr = '0;
  logic [15:0] prev_wd = '0;

  always #2.5 clk = ~clk;

  wb2way_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready_o), .rdata_o(rdata_o), .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'(8'hA0 + a);
  endfunction

  // backing memory: acks on the second cycle of a request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat     <= 1'b0;
      for (int b = 0; b < 8; b++) mem_q[b] <= {mem_byte(2*b+1), mem_byte(2*b)};
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req_o) begin
      if (lat) begin
        lat     <= 1'b0;
        mem_ack <= 1'b1;
        txn_we[txn_n]   <= mem_we_o;
        txn_addr[txn_n] <= mem_addr_o;
        txn_data[txn_n] <= mem_wdata_o;
        txn_n <= txn_n + 1;
        if (mem_we_o) begin
          mem_q[mem_addr_o] <= mem_wdata_o;
          wr_n <= wr_n + 1;
        end else begin
          mem_rdata <= mem_q[mem_addr_o];
          rd_n <= rd_n + 1;
        end
      end else begin
        lat <= 1'b1;
      end
    end
  end

  // protocol monitors (R10, R12)
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend && !(mem_req_o && mem_addr_o == prev_addr && mem_we_o == prev_we &&
                         mem_wdata_o == prev_wd)) hs_err++;
      if (ready_o && prev_rdy) rdy_err++;
      prev_pend = mem_req_o && !mem_ack;
      prev_addr = mem_addr_o;
      prev_we   = mem_we_o;
      prev_wd   = mem_wdata_o;
      prev_rdy  = ready_o;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d,
                        input bit exp_hit, input int exp_wr, input logic [7:0] exp_byte,
                        input string rq);
    int cyc = 0;
    int h0 = hit_cnt_o, m0 = miss_cnt_o, r0 = rd_n, w0 = wr_n;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    forever begin
      @(negedge clk);
      cyc++;
      if (ready_o || cyc > 50) break;
    end
    req = 1'b0;
    if (exp_hit) exp_hits++; else exp_misses++;
    chk(ready_o == 1'b1, rq, "ready", ready_o, 1);
    chk(rdata_o == exp_byte, rq, "rdata", rdata_o, exp_byte);
    chk(int'(hit_cnt_o) == h0 + (exp_hit ? 1 : 0), "R9", "hit count", hit_cnt_o, h0 + (exp_hit ? 1 : 0));
    chk(int'(miss_cnt_o) == m0 + (exp_hit ? 0 : 1), "R9", "miss count", miss_cnt_o, m0 + (exp_hit ? 0 : 1));
    chk(wr_n - w0 == exp_wr, rq, "mem writes", wr_n - w0, exp_wr);
    if (exp_hit) begin
      chk(cyc == 1, "R2", "hit latency", cyc, 1);
      chk(rd_n == r0, "R2", "hit mem reads", rd_n - r0, 0);
    end else begin
      chk(rd_n - r0 == 1, "R3", "miss fill reads", rd_n - r0, 1);
    end
  endtask

  task automatic t_reset;
    chk(ready_o == 1'b0, "R11", "ready after reset", ready_o, 0);
    chk(hit_cnt_o == 0 && miss_cnt_o == 0, "R11", "counters after reset", hit_cnt_o + miss_cnt_o, 0);
    chk(mem_req_o == 1'b0, "R11", "mem idle after reset", mem_req_o, 0);
  endtask

  task automatic t_cold_and_ways;
    access(1'b0, 4'd1, 8'h00, 1'b0, 0, mem_byte(1), "R11");   // first access misses
    chk(txn_addr[txn_n-1] == 3'd0, "R1", "fill line address", txn_addr[txn_n-1], 0);
    access(1'b0, 4'd0, 8'h00, 1'b1, 0, mem_byte(0), "R1");    // offset 0 = low byte
    access(1'b0, 4'd8, 8'h00, 1'b0, 0, mem_byte(8), "R3");
    access(1'b0, 4'd1, 8'h00, 1'b1, 0, mem_byte(1), "R4");    // both lines resident
    access(1'b0, 4'd9, 8'h00, 1'b1, 0, mem_byte(9), "R4");
  endtask

  task automatic t_store_miss;
    // line 0 is non-MRU and clean: evicted with no write
    access(1'b1, 4'd4, 8'h55, 1'b0, 0, 8'h55, "R7");
    access(1'b0, 4'd4, 8'h00, 1'b1, 0, 8'h55, "R7");
  endtask

  task automatic t_mru_replace;
    access(1'b0, 4'd1, 8'h00, 1'b0, 0, mem_byte(1), "R5");    // line 0 was evicted
  endtask

  task automatic t_dirty_wb;
    int n0;
    n0 = txn_n;
    access(1'b0, 4'd9, 8'h00, 1'b0, 1, mem_byte(9), "R5");    // line 4 evicted earlier
    chk(txn_n - n0 == 2, "R8", "txn count", txn_n - n0, 2);
    chk(txn_we[n0] == 1'b1 && txn_addr[n0] == 3'd2, "R8", "write-back first to line 2",
        {txn_we[n0], txn_addr[n0]}, 4'hA);
    chk(txn_data[n0] == 16'hA555, "R8", "write-back data", txn_data[n0], 16'hA555);
    chk(txn_we[n0+1] == 1'b0 && txn_addr[n0+1] == 3'd4, "R8", "fill after write-back",
        {txn_we[n0+1], txn_addr[n0+1]}, 4'h4);
    access(1'b0, 4'd4, 8'h00, 1'b0, 0, 8'h55, "R8");          // reload sees merged byte
  endtask

  task automatic t_store_hit;
    access(1'b1, 4'd9, 8'h77, 1'b1, 0, 8'h77, "R6");
    access(1'b0, 4'd9, 8'h00, 1'b1, 0, 8'h77, "R6");
    access(1'b0, 4'd8, 8'h00, 1'b1, 0, mem_byte(8), "R6");
  endtask

  task automatic t_other_set;
    access(1'b1, 4'd3, 8'h3C, 1'b0, 0, 8'h3C, "R1");
    access(1'b0, 4'd2, 8'h00, 1'b1, 0, mem_byte(2), "R7");
    access(1'b0, 4'd3, 8'h00, 1'b1, 0, 8'h3C, "R7");
    access(1'b0, 4'd9, 8'h00, 1'b1, 0, 8'h77, "R1");          // set 0 untouched
  endtask

  task automatic t_protocol;
    chk(hs_err == 0, "R10", "handshake hold violations", hs_err, 0);
    chk(rdy_err == 0, "R12", "ready wider than one cycle", rdy_err, 0);
    chk(int'(hit_cnt_o) == exp_hits, "R9", "total hits", hit_cnt_o, exp_hits);
    chk(int'(miss_cnt_o) == exp_misses, "R9", "total misses", miss_cnt_o, exp_misses);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_cold_and_ways;
    t_store_miss;
    t_mru_replace;
    t_dirty_wb;
    t_store_hit;
    t_other_set;
    repeat (3) @(negedge clk);
    t_protocol;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule